// File: doc/BRIEF.md
# Scratchpad Copy and Memory Read Command Engine

This block is the byte-level command stage of a single-wire serial memory slave. Once the bus layer has handled the reset, presence and device selection, it hands this engine whole bytes from the master (`rx_valid_i`) and asks for answer bytes (`tx_req_i`). The engine holds a 144-byte memory array, an 8-byte scratchpad, a 16-bit target address and an ending-offset/status byte. It serves three functions: reading the scratchpad back with a check code, copying the scratchpad into the array after an authorization echo, and streaming the array from any address.

The scratchpad is filled through a preload port, which stands in for the write command. A per-row protect input marks rows of eight bytes that may not be written. A copy runs for a parameterized number of cycles. After a copy the engine answers with a status stream until the bus layer signals a bus reset. Every answer path ends in a defined fill value.

Top module: `sp_eeprom_engine`

## Requirements
- R1: After `rst_ni` or a bus reset, the engine waits for a command byte. A read request made there returns 8'hFF.
- R2: Each cycle with `tx_req_i` high is answered in the next cycle with `tx_valid_o` high and the byte on `tx_byte_o`. `tx_valid_o` is low otherwise.
- R3: Command 8'hAA (scratchpad read) returns the address low byte, the address high byte and the status byte, in that order. It then returns scratchpad bytes from offset T (address bits 2:0) up to offset E (status bits 2:0), wrapping modulo 8, which is ((E-T) mod 8)+1 bytes.
- R4: After the last scratchpad byte comes the check code, low byte first, both bytes inverted. The code is CRC-16 (x^16+x^15+x^2+1, reflected, shifted LSB first, start value 0) over every byte the engine sent since the command. Every later read returns 8'hFF.
- R5: Command 8'h55 (copy) takes three bytes that must equal the address low byte, the address high byte and the status byte. On any mismatch nothing is written, status bit 7 stays clear and reads return 8'hFF.
- R6: A copy is also refused when the target address is 144 or more, when status bit 5 (the preload fault flag) is set, or when the protect bit of the target row is set.
- R7: An accepted copy sets status bit 7 and writes all 8 scratchpad bytes into the row starting at address & ~7 after COPY_CYCLES cycles. While the copy runs, reads return 8'hFF and incoming bytes are ignored.
- R8: After a finished copy, every read returns 8'hAA until a bus reset.
- R9: Command 8'hF0 (memory read) takes a 2-byte address, low byte first. It then streams the array from that address upward and returns 8'hFF for any address of 144 or more.
- R10: A memory read leaves the target address, the status byte and the scratchpad unchanged.
- R11: Any other command byte makes every later read return 8'hFF and every later byte be ignored until a bus reset.
- R12: A bus reset takes priority in any state. It returns the engine to command wait. A copy that has not yet written, including one whose last cycle coincides with the reset, is dropped without a write.
- R13: A preload sets the address and the scratchpad, and sets the status byte to {0,0,fault,0,0,E}, which clears bit 7. A preload is ignored while a copy command is collecting authorization or running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | Bus reset from the bit layer; returns to command wait |
| rx_valid_i | input | 1 | A byte from the master is present |
| rx_byte_i | input | 8 | Byte from the master |
| tx_req_i | input | 1 | Master requests one answer byte |
| tx_valid_o | output | 1 | Answer byte valid, one cycle after the request |
| tx_byte_o | output | 8 | Answer byte |
| pre_load_i | input | 1 | Preload strobe for address, status and scratchpad |
| pre_ta_i | input | 16 | Preloaded target address |
| pre_end_i | input | 3 | Preloaded ending offset E |
| pre_pf_i | input | 1 | Preloaded fault flag (status bit 5) |
| pre_data_i | input | 64 | Preloaded scratchpad, byte k in bits 8k+7:8k |
| row_protect_i | input | MEM_BYTES/8 | Per-row write protect, bit r covers addresses 8r..8r+7 |

## Verification
The copy timer finishing its count and a bus reset arriving can happen in the same cycle, and the reset has to win so the row is not written. The bench accepts a copy and then places the bus reset exactly on the final count cycle. In a second run it places the reset one cycle later. It then reads the target row back through the memory read command: the first case must show the old contents and the second the scratchpad bytes.

// File: rtl/sp_eng_pkg.sv
package sp_eng_pkg;

  localparam int SP_BYTES = 8;
  localparam int SP_OFF_W = $clog2(SP_BYTES);

  localparam logic [7:0] CMD_RD_SP  = 8'hAA;
  localparam logic [7:0] CMD_COPY   = 8'h55;
  localparam logic [7:0] CMD_RD_MEM = 8'hF0;
  localparam logic [7:0] FILL_BYTE  = 8'hFF;
  localparam logic [7:0] DONE_BYTE  = 8'hAA;

  localparam int ES_AA = 7;
  localparam int ES_PF = 5;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_RSP,
    ST_AUTH,
    ST_COPY,
    ST_DONE,
    ST_ADDR,
    ST_MEM,
    ST_DEAD
  } eng_state_e;

  // reflected CRC-16, poly 0x8005
  function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/sp_mem_array.sv
module sp_mem_array #(
  parameter int MEM_BYTES = 144,
  parameter int ROW_BYTES = 8,
  localparam int NUM_ROWS = MEM_BYTES / ROW_BYTES,
  localparam int ROW_W    = $clog2(NUM_ROWS),
  localparam int ADDR_W   = $clog2(MEM_BYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ROW_W-1:0]       row_i,
  input  logic [ROW_BYTES*8-1:0] wdata_i,
  input  logic [ADDR_W-1:0]      raddr_i,
  output logic [7:0]             rdata_o
);

  logic [MEM_BYTES*8-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i) begin
      for (int b = 0; b < ROW_BYTES; b++) begin
        mem_q[(int'(row_i) * ROW_BYTES + b) * 8 +: 8] <= wdata_i[b*8 +: 8];
      end
    end
  end

  assign rdata_o = (int'(raddr_i) < MEM_BYTES) ? mem_q[int'(raddr_i) * 8 +: 8] : 8'hFF;

  p_row_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (int'(row_i) < NUM_ROWS));

endmodule

// File: rtl/sp_scratch_regs.sv
module sp_scratch_regs
  import sp_eng_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [15:0]           load_ta_i,
  input  logic [SP_OFF_W-1:0]   load_end_i,
  input  logic                  load_pf_i,
  input  logic [SP_BYTES*8-1:0] load_data_i,
  input  logic                  set_aa_i,
  output logic [15:0]           ta_o,
  output logic [7:0]            es_o,
  output logic [SP_BYTES*8-1:0] data_o
);

  logic [15:0]           ta_q;
  logic [7:0]            es_q;
  logic [SP_BYTES*8-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ta_q   <= '0;
      es_q   <= '0;
      data_q <= '0;
    end else if (load_i) begin
      ta_q   <= load_ta_i;
      es_q   <= {2'b00, load_pf_i, 2'b00, load_end_i};
      data_q <= load_data_i;
    end else if (set_aa_i) begin
      es_q[ES_AA] <= 1'b1;
    end
  end

  assign ta_o   = ta_q;
  assign es_o   = es_q;
  assign data_o = data_q;

  p_aa_needs_pf_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_aa_i |-> !es_q[ES_PF]);

endmodule

// File: rtl/sp_copy_timer.sv
module sp_copy_timer #(
  parameter int COPY_CYCLES = 40,
  localparam int CNT_W = $clog2(COPY_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (abort_i)        cnt_q <= '0;
    else if (start_i)        cnt_q <= CNT_W'(COPY_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  p_start_arms_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !abort_i) |=> busy_o);

  p_done_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !busy_o);

endmodule

// File: rtl/sp_eeprom_engine.sv
module sp_eeprom_engine
  import sp_eng_pkg::*;
#(
  parameter int MEM_BYTES   = 144,
  parameter int COPY_CYCLES = 40
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_reset_i,
  input  logic                   rx_valid_i,
  input  logic [7:0]             rx_byte_i,
  input  logic                   tx_req_i,
  output logic                   tx_valid_o,
  output logic [7:0]             tx_byte_o,
  input  logic                   pre_load_i,
  input  logic [15:0]            pre_ta_i,
  input  logic [2:0]             pre_end_i,
  input  logic                   pre_pf_i,
  input  logic [63:0]            pre_data_i,
  input  logic [MEM_BYTES/8-1:0] row_protect_i
);

  localparam int NUM_ROWS = MEM_BYTES / SP_BYTES;
  localparam int ROW_W    = $clog2(NUM_ROWS);
  localparam int ADDR_W   = $clog2(MEM_BYTES);

  eng_state_e state_q;
  logic [3:0]  pos_q;
  logic [15:0] crc_q;
  logic        match_q;
  logic [15:0] rd_ptr_q;
  logic        tx_valid_q;
  logic [7:0]  tx_byte_q;

  logic [15:0]           ta;
  logic [7:0]            es;
  logic [SP_BYTES*8-1:0] sp_data;
  logic                  copy_busy, copy_done;
  logic                  load_ok, accept_fire, mem_we;
  logic [7:0]            mem_rdata;

  // scratchpad read stream
  logic [SP_OFF_W-1:0] t_off, e_off, sp_sel;
  logic [3:0]          n_data, data_idx;
  logic                sp_in_crc;
  logic [7:0]          sp_byte;

  assign t_off    = ta[SP_OFF_W-1:0];
  assign e_off    = es[SP_OFF_W-1:0];
  assign n_data   = {1'b0, e_off - t_off} + 4'd1;
  assign data_idx = pos_q - 4'd3;
  assign sp_sel   = t_off + data_idx[SP_OFF_W-1:0];
  assign sp_in_crc = (pos_q < 4'd3 + n_data);

  always_comb begin
    if (pos_q == 4'd0)                   sp_byte = ta[7:0];
    else if (pos_q == 4'd1)              sp_byte = ta[15:8];
    else if (pos_q == 4'd2)              sp_byte = es;
    else if (sp_in_crc)                  sp_byte = sp_data[{sp_sel, 3'b000} +: 8];
    else if (pos_q == 4'd3 + n_data)     sp_byte = ~crc_q[7:0];
    else if (pos_q == 4'd4 + n_data)     sp_byte = ~crc_q[15:8];
    else                                 sp_byte = FILL_BYTE;
  end

  // copy authorization
  logic [7:0]     auth_exp;
  logic           auth_match, addr_valid, auth_ok;
  logic [ROW_W-1:0] copy_row;

  always_comb begin
    case (pos_q)
      4'd0:    auth_exp = ta[7:0];
      4'd1:    auth_exp = ta[15:8];
      default: auth_exp = es;
    endcase
  end

  assign copy_row   = ROW_W'(ta >> SP_OFF_W);
  assign addr_valid = (ta < 16'(MEM_BYTES));
  assign auth_match = match_q && (rx_byte_i == auth_exp);
  assign auth_ok    = auth_match && addr_valid && !es[ES_PF] && !row_protect_i[copy_row];

  assign accept_fire = (state_q == ST_AUTH) && rx_valid_i && (pos_q == 4'd2)
                     && auth_ok && !bus_reset_i;
  assign mem_we      = (state_q == ST_COPY) && copy_done && !bus_reset_i;
  assign load_ok     = pre_load_i && !copy_busy && (state_q != ST_AUTH);

  // memory read stream
  logic       rd_in_range;
  logic [7:0] mem_byte;

  assign rd_in_range = (rd_ptr_q < 16'(MEM_BYTES));
  assign mem_byte    = rd_in_range ? mem_rdata : FILL_BYTE;

  logic [7:0] tx_next;
  always_comb begin
    case (state_q)
      ST_RSP:  tx_next = sp_byte;
      ST_MEM:  tx_next = mem_byte;
      ST_DONE: tx_next = DONE_BYTE;
      default: tx_next = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_CMD;
      pos_q    <= '0;
      crc_q    <= '0;
      match_q  <= 1'b0;
      rd_ptr_q <= '0;
    end else if (bus_reset_i) begin
      state_q <= ST_CMD;
      pos_q   <= '0;
    end else begin
      case (state_q)
        ST_CMD: if (rx_valid_i) begin
          pos_q   <= '0;
          crc_q   <= '0;
          match_q <= 1'b1;
          case (rx_byte_i)
            CMD_RD_SP:  state_q <= ST_RSP;
            CMD_COPY:   state_q <= ST_AUTH;
            CMD_RD_MEM: state_q <= ST_ADDR;
            default:    state_q <= ST_DEAD;
          endcase
        end
        ST_RSP: if (tx_req_i) begin
          if (sp_in_crc) crc_q <= crc16_step(crc_q, sp_byte);
          if (pos_q != 4'hF) pos_q <= pos_q + 4'd1;
        end
        ST_AUTH: if (rx_valid_i) begin
          if (pos_q == 4'd2) begin
            state_q <= auth_ok ? ST_COPY : ST_DEAD;
          end else begin
            pos_q   <= pos_q + 4'd1;
            match_q <= auth_match;
          end
        end
        ST_COPY: if (copy_done) state_q <= ST_DONE;
        ST_ADDR: if (rx_valid_i) begin
          if (pos_q == 4'd0) begin
            rd_ptr_q[7:0] <= rx_byte_i;
            pos_q         <= 4'd1;
          end else begin
            rd_ptr_q[15:8] <= rx_byte_i;
            state_q        <= ST_MEM;
          end
        end
        ST_MEM: if (tx_req_i && rd_in_range) rd_ptr_q <= rd_ptr_q + 16'd1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_q <= 1'b0;
      tx_byte_q  <= FILL_BYTE;
    end else begin
      tx_valid_q <= tx_req_i;
      if (tx_req_i) tx_byte_q <= bus_reset_i ? FILL_BYTE : tx_next;
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_byte_o  = tx_byte_q;

  sp_scratch_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_ok),
    .load_ta_i   (pre_ta_i),
    .load_end_i  (pre_end_i),
    .load_pf_i   (pre_pf_i),
    .load_data_i (pre_data_i),
    .set_aa_i    (accept_fire),
    .ta_o        (ta),
    .es_o        (es),
    .data_o      (sp_data)
  );

  sp_copy_timer #(.COPY_CYCLES(COPY_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept_fire),
    .abort_i (bus_reset_i),
    .busy_o  (copy_busy),
    .done_o  (copy_done)
  );

  sp_mem_array #(.MEM_BYTES(MEM_BYTES), .ROW_BYTES(SP_BYTES)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .row_i   (copy_row),
    .wdata_i (sp_data),
    .raddr_i (rd_ptr_q[ADDR_W-1:0]),
    .rdata_o (mem_rdata)
  );

  p_reset_to_cmd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (state_q == ST_CMD));

  p_tx_answers_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_i |=> tx_valid_o);

  p_busy_reads_ff_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COPY && tx_req_i && !bus_reset_i) |=> (tx_byte_o == FILL_BYTE));

  p_write_after_aa_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> es[ES_AA]);

  p_rdmem_keeps_regs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_ADDR || state_q == ST_MEM) && !pre_load_i)
      |=> ($stable(ta) && $stable(es) && $stable(sp_data)));

  p_copy_blocks_load_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COPY) |=> ($stable(ta) && $stable(sp_data)));

  p_dead_reads_ff_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEAD && tx_req_i && !bus_reset_i) |=> (tx_byte_o == FILL_BYTE));

endmodule

// File: tb/sp_eeprom_engine_test.sv
module sp_eeprom_engine_test;

  localparam int CLK_PERIOD  = 10;
  localparam int MEM_BYTES   = 144;
  localparam int COPY_CYCLES = 40;
  localparam int NUM_ROWS    = MEM_BYTES / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_reset = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic tx_req = 1'b0;
  logic tx_valid;
  logic [7:0] tx_byte;
  logic pre_load = 1'b0;
  logic [15:0] pre_ta = '0;
  logic [2:0] pre_end = '0;
  logic pre_pf = 1'b0;
  logic [63:0] pre_data = '0;
  logic [NUM_ROWS-1:0] prot = '0;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [7:0]  m_mem [MEM_BYTES];
  logic [15:0] m_ta;
  logic [2:0]  m_end;
  logic        m_pf;
  logic        m_aa;
  logic [63:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_eeprom_engine #(.MEM_BYTES(MEM_BYTES), .COPY_CYCLES(COPY_CYCLES)) uut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .bus_reset_i   (bus_reset),
    .rx_valid_i    (rx_valid),
    .rx_byte_i     (rx_byte),
    .tx_req_i      (tx_req),
    .tx_valid_o    (tx_valid),
    .tx_byte_o     (tx_byte),
    .pre_load_i    (pre_load),
    .pre_ta_i      (pre_ta),
    .pre_end_i     (pre_end),
    .pre_pf_i      (pre_pf),
    .pre_data_i    (pre_data),
    .row_protect_i (prot)
  );

  function automatic logic [15:0] crc_byte(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 16'hA001;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [7:0] m_es();
    return {m_aa, 1'b0, m_pf, 2'b00, m_end};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic rd(output logic [7:0] b);
    @(negedge clk);
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    b = tx_byte;
  endtask

  task automatic breset();
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
  endtask

  task automatic preload(input logic [15:0] ta, input logic [2:0] e, input logic pf,
                         input logic [63:0] d, input bit applies);
    @(negedge clk);
    pre_load = 1'b1;
    pre_ta = ta; pre_end = e; pre_pf = pf; pre_data = d;
    @(negedge clk);
    pre_load = 1'b0;
    if (applies) begin
      m_ta = ta; m_end = e; m_pf = pf; m_data = d; m_aa = 1'b0;
    end
  endtask

  // R3 R4: full scratchpad read against the model
  task automatic rd_sp_check(input string req);
    logic [7:0] b, exp;
    logic [15:0] crc;
    int n;
    n = int'(3'(m_end - m_ta[2:0])) + 1;
    crc = '0;
    send(8'hAA);
    for (int k = 0; k < 3 + n; k++) begin
      if (k == 0)      exp = m_ta[7:0];
      else if (k == 1) exp = m_ta[15:8];
      else if (k == 2) exp = m_es();
      else             exp = m_data[{3'(m_ta[2:0] + 3'(k - 3)), 3'b000} +: 8];
      rd(b);
      chk({req, " R3 stream"}, {8'h00, b}, {8'h00, exp});
      crc = crc_byte(crc, exp);
    end
    rd(b); chk({req, " R4 crc lo"}, {8'h00, b}, {8'h00, ~crc[7:0]});
    rd(b); chk({req, " R4 crc hi"}, {8'h00, b}, {8'h00, ~crc[15:8]});
    rd(b); chk({req, " R4 fill"},   {8'h00, b}, 16'h00FF);
    breset();
  endtask

  // R9: memory read against the model
  task automatic rd_mem_check(input int addr, input int count, input string req);
    logic [7:0] b, exp;
    send(8'hF0);
    send(addr[7:0]);
    send(addr[15:8]);
    for (int k = 0; k < count; k++) begin
      exp = (addr + k < MEM_BYTES) ? m_mem[addr + k] : 8'hFF;
      rd(b);
      chk(req, {8'h00, b}, {8'h00, exp});
    end
    breset();
  endtask

  task automatic model_write_row();
    for (int i = 0; i < 8; i++) m_mem[(int'(m_ta) & ~7) + i] = m_data[i*8 +: 8];
  endtask

  task automatic do_copy(input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2,
                         input bit expect_ok, input string req);
    logic [7:0] b;
    send(8'h55); send(a0); send(a1); send(a2);
    rd(b);
    chk({req, " R7 busy or refused"}, {8'h00, b}, 16'h00FF);
    repeat (COPY_CYCLES) @(negedge clk);
    rd(b);
    chk({req, " R8 after copy"}, {8'h00, b}, expect_ok ? 16'h00AA : 16'h00FF);
    if (expect_ok) begin
      m_aa = 1'b1;
      model_write_row();
    end
    breset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < MEM_BYTES; i++) m_mem[i] = 8'h00;
    m_ta = '0; m_end = '0; m_pf = 1'b0; m_aa = 1'b0; m_data = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2: idle read
    chk("R2 valid idle", {15'd0, tx_valid}, 16'd0);
    @(negedge clk);
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    chk("R2 valid after request", {15'd0, tx_valid}, 16'd1);
    chk("R1 idle read", {8'h00, tx_byte}, 16'h00FF);
    @(negedge clk);
    chk("R2 valid drops", {15'd0, tx_valid}, 16'd0);

    // R11: unknown command then ignored bytes
    send(8'h33);
    send(8'hF0); send(8'h00); send(8'h00);
    rd(b); chk("R11 unknown command", {8'h00, b}, 16'h00FF);
    breset();
    rd(b); chk("R1 after bus reset", {8'h00, b}, 16'h00FF);

    // R13: preload status layout and scratchpad read
    preload(16'h0012, 3'd5, 1'b0, 64'h8877_6655_4433_2211, 1'b1);
    rd_sp_check("R13 preload");

    // R3: offset wrap (T=6, E=1)
    preload(16'h001E, 3'd1, 1'b0, 64'hF0E0_D0C0_B0A0_9080, 1'b1);
    rd_sp_check("R3 wrap");

    // R5: mismatched authorization
    preload(16'h0020, 3'd7, 1'b0, 64'h0102_0304_0506_0708, 1'b1);
    do_copy(8'h20, 8'h01, m_es(), 1'b0, "R5 mismatch");
    rd_mem_check(32, 8, "R5 row untouched");
    rd_sp_check("R5 aa clear");

    // R6: fault flag
    preload(16'h0028, 3'd7, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1);
    do_copy(8'h28, 8'h00, m_es(), 1'b0, "R6 fault flag");
    rd_mem_check(40, 8, "R6 fault row untouched");

    // R6: protected row
    prot = '0;
    prot[6] = 1'b1;
    preload(16'h0030, 3'd7, 1'b0, 64'h1111_2222_3333_4444, 1'b1);
    do_copy(8'h30, 8'h00, m_es(), 1'b0, "R6 protected");
    rd_mem_check(48, 8, "R6 protected row untouched");
    prot = '0;

    // R6: address out of range
    preload(16'h0090, 3'd7, 1'b0, 64'h5555_6666_7777_8888, 1'b1);
    do_copy(8'h90, 8'h00, m_es(), 1'b0, "R6 bad address");
    preload(16'h0108, 3'd7, 1'b0, 64'h5555_6666_7777_8888, 1'b1);
    do_copy(8'h08, 8'h01, m_es(), 1'b0, "R6 bad high byte");
    rd_mem_check(8, 8, "R6 row 1 untouched");

    // R7 R13: accepted copy with bytes and preload during it
    preload(16'h0088, 3'd7, 1'b0, 64'hC7C6_C5C4_C3C2_C1C0, 1'b1);
    send(8'h55); send(8'h88); send(8'h00); send(m_es());
    send(8'hF0); send(8'h00); send(8'h00);
    preload(16'h0000, 3'd3, 1'b0, 64'hDEAD_BEEF_DEAD_BEEF, 1'b0);
    rd(b); chk("R7 read while busy", {8'h00, b}, 16'h00FF);
    repeat (COPY_CYCLES) @(negedge clk);
    rd(b); chk("R8 status stream 1", {8'h00, b}, 16'h00AA);
    rd(b); chk("R8 status stream 2", {8'h00, b}, 16'h00AA);
    rd(b); chk("R8 status stream 3", {8'h00, b}, 16'h00AA);
    m_aa = 1'b1;
    model_write_row();
    breset();
    rd_sp_check("R13 preload ignored in copy");
    // R9: read crossing the end of the array
    rd_mem_check(16'h008C, 7, "R9 past end");
    rd_mem_check(16'h0100, 3, "R9 high address");

    // R12: bus reset on the final copy cycle drops the write
    preload(16'h0040, 3'd7, 1'b0, 64'h9999_9999_9999_9999, 1'b1);
    send(8'h55); send(8'h40); send(8'h00); send(m_es());
    repeat (COPY_CYCLES - 1) @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    m_aa = 1'b1;
    rd(b); chk("R12 command wait after reset", {8'h00, b}, 16'h00FF);
    rd_mem_check(64, 8, "R12 reset on last cycle no write");

    // R12: bus reset one cycle later keeps the write
    preload(16'h0040, 3'd7, 1'b0, 64'h9999_9999_9999_9999, 1'b1);
    send(8'h55); send(8'h40); send(8'h00); send(m_es());
    repeat (COPY_CYCLES) @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    m_aa = 1'b1;
    model_write_row();
    rd_mem_check(64, 8, "R12 reset after write");

    // random mix: R3 R4 R7 R9 R10
    for (int it = 0; it < 24; it++) begin
      logic [15:0] ta;
      logic [63:0] d;
      logic        pf;
      int          row;
      row = int'($urandom_range(0, NUM_ROWS - 1));
      ta  = 16'(row * 8 + int'($urandom_range(0, 7)));
      d   = {$urandom, $urandom};
      pf  = ($urandom_range(0, 3) == 0);
      prot = NUM_ROWS'({$urandom, $urandom}) & NUM_ROWS'({$urandom, $urandom});
      preload(ta, 3'($urandom_range(0, 7)), pf, d, 1'b1);
      rd_mem_check(int'($urandom_range(0, MEM_BYTES + 4)), 5, "R9 random read");
      rd_sp_check("R10 regs kept after memory read");
      do_copy(m_ta[7:0], m_ta[15:8], m_es(), !m_pf && !prot[row], "R7 random copy");
      rd_mem_check(row * 8, 8, "R7 random row");
    end
    prot = '0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule